// File: doc/BRIEF.md
# Dual-Clock Pointer-Reset Line Delay Buffer

This block stores one scan line of 8-bit samples and plays it back on a second, unrelated clock. The write side and the read side each own an address pointer that advances by one word on every enabled rising edge of its own clock. A pointer goes back to word zero only when its own pointer-reset input is pulsed. There are no full or empty flags. The spacing between the two resets alone sets the line length and the delay.

The block has two typical uses. With both ports on one clock, pulsing the read reset n cycles after the write reset delays the stream by exactly n words. With a faster read clock, a stored line can be played back at a different rate, or read twice in the time it took to write it once. The read output is a data bus plus a drive-enable for a three-state pad. The enable is low whenever no read took place in the last read cycle.

Top module: `line_delay_buf`

## Requirements
- R1: At a `wr_clk` rising edge with `wr_zero` high, the write pointer becomes 0 whether `wr_go` is high or low. No word is stored in that cycle.
- R2: At a `wr_clk` edge with `wr_zero` low and `wr_go` high, `wr_data` is stored at the write pointer and the pointer advances by one. With `wr_go` low, nothing is stored and the pointer holds its value.
- R3: At an `rd_clk` rising edge with `rd_zero` high, the read pointer becomes 0 whether `rd_go` is high or low. After that edge `rd_drive` is 0.
- R4: At an `rd_clk` edge with `rd_zero` low and `rd_go` high, the word at the read pointer appears on `rd_data`, with `rd_drive` at 1, right after that same edge. The read pointer then advances by one.
- R5: At an `rd_clk` edge with `rd_go` low, the read pointer holds its value and `rd_drive` is 0 after the edge. The next enabled read continues from the held address.
- R6: With no reset, each pointer wraps from the last word (DEPTH-1 = 5047) to word 0.
- R7: With both ports on a common clock and both enables high, the read reset is pulsed n cycles after the write reset, for any n from 21 to DEPTH. Each word then comes out n cycles after it was written. A read and a write of the same address at the same edge return the older word.
- R8: The two clocks are independent. A stored line of DEPTH words can be read twice in a row with a read clock at twice the write rate.
- R9: The storage holds DEPTH = 5048 words of WIDTH = 8 bits, and both pointers always stay below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_go | input | 1 | Write enable: store and advance |
| wr_zero | input | 1 | Write pointer reset to word 0 |
| wr_data | input | 8 | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_go | input | 1 | Read enable: fetch and advance |
| rd_zero | input | 1 | Read pointer reset to word 0 |
| rd_data | output | 8 | Word fetched in the last read cycle |
| rd_drive | output | 1 | Pad drive enable; 0 means the bus is high impedance |

## Verification
Every result is due one clock edge after its stimulus: a pointer reset, a write, or a read. A fetched word and the drive-enable both change at the read edge that samples `rd_go`, and a stored word can be read from the next write edge on. In the common-clock runs, the bench drives new inputs and samples outputs 1 ns after each edge. In the double-rate run it does the same 0.5 ns after each read edge, so every sample sees the value the previous edge produced. For a delay of n, the bench expects the first written word at edge n+1 after the write reset, and derives the words after it from the write index.

// File: rtl/line_delay_pkg.sv
package line_delay_pkg;
   localparam int unsigned LINE_WORDS = 5048;
   localparam int unsigned WORD_BITS  = 8;
   localparam int unsigned MIN_SPAN   = 21;

   // state of one pointer for the current edge
   typedef enum logic [1:0] {
      PTR_HOLD  = 2'd0,
      PTR_STEP  = 2'd1,
      PTR_CLEAR = 2'd2
   } ptr_act_e;
endpackage

// File: rtl/lb_ptr.sv
module lb_ptr
   import line_delay_pkg::*;
#(
   parameter int unsigned DEPTH = LINE_WORDS,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic          clk,
   input  logic          clr,
   input  logic          en,
   output logic [AW-1:0] ptr,
   output logic          armed
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   ptr_act_e act;
   bit       known = 1'b0;

   always_comb begin
      if (clr)     act = PTR_CLEAR;
      else if (en) act = PTR_STEP;
      else         act = PTR_HOLD;
   end

   always_ff @(posedge clk) begin
      unique case (act)
         PTR_CLEAR: ptr <= '0;
         PTR_STEP:  ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
         default:   ptr <= ptr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (clr) known <= 1'b1;
   end

   assign armed = known;

   // R1 / R3: a pointer reset lands on word zero
   p_ptr_clear_r1: assert property (@(posedge clk) disable iff (!known)
      clr |=> ptr == '0);

   // R2 / R5: idle pointer holds
   p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!known)
      (!clr && !en) |=> $stable(ptr));

   // R6: enabled step, with wrap after the last word
   p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!known)
      (!clr && en && ptr == LAST) |=> ptr == '0);

   // R9: pointer never leaves the array
   p_ptr_range_r9: assert property (@(posedge clk) disable iff (!known)
      1'b1 |=> ptr <= LAST);
endmodule

// File: rtl/lb_store.sv
module lb_store
   import line_delay_pkg::*;
#(
   parameter int unsigned DEPTH = LINE_WORDS,
   parameter int unsigned WIDTH = WORD_BITS,
   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic             wclk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rclk,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   always_ff @(posedge rclk) begin
      if (re) rdata <= cells[raddr];
   end
endmodule

// File: rtl/lb_rd_out.sv
module lb_rd_out
   import line_delay_pkg::*;
#(
   parameter int unsigned WIDTH    = WORD_BITS,
   parameter bit          MUTE_OFF = 1'b1
)(
   input  logic             rclk,
   input  logic             armed,
   input  logic             go,
   input  logic             zero,
   input  logic [WIDTH-1:0] word,
   output logic [WIDTH-1:0] bus,
   output logic             drive
);
   logic oe_q;

   always_ff @(posedge rclk) begin
      oe_q <= go & ~zero;
   end

   assign drive = oe_q;

   generate
      if (MUTE_OFF) begin : g_mute
         assign bus = oe_q ? word : '0;
      end else begin : g_pass
         assign bus = word;
      end
   endgenerate

   // R5: no read, no drive
   p_idle_off_r5: assert property (@(posedge rclk) disable iff (!armed)
      !go |=> !drive);

   // R3: reset cycle never drives
   p_reset_off_r3: assert property (@(posedge rclk) disable iff (!armed)
      zero |=> !drive);

   // R4: a real read drives the bus next
   p_read_drive_r4: assert property (@(posedge rclk) disable iff (!armed)
      (go && !zero) |=> drive);
endmodule

// File: rtl/line_delay_buf.sv
module line_delay_buf
   import line_delay_pkg::*;
#(
   parameter int unsigned DEPTH    = LINE_WORDS,
   parameter int unsigned WIDTH    = WORD_BITS,
   parameter int unsigned MIN_DLY  = MIN_SPAN,
   parameter bit          MUTE_OFF = 1'b1
)(
   input  logic             wr_clk,
   input  logic             wr_go,
   input  logic             wr_zero,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_clk,
   input  logic             rd_go,
   input  logic             rd_zero,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_drive
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("line_delay_buf: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("line_delay_buf: WIDTH must be at least 1");
      end
      if (MIN_DLY > DEPTH) begin : g_bad_span
         $error("line_delay_buf: MIN_DLY exceeds DEPTH");
      end
   endgenerate

   logic [AW-1:0]    wptr, rptr;
   logic             w_armed, r_armed;
   logic             w_store, r_fetch;
   logic [WIDTH-1:0] fetched;

   assign w_store = wr_go & ~wr_zero;
   assign r_fetch = rd_go & ~rd_zero;

   lb_ptr #(.DEPTH(DEPTH)) u_wptr (
      .clk(wr_clk), .clr(wr_zero), .en(wr_go), .ptr(wptr), .armed(w_armed)
   );

   lb_ptr #(.DEPTH(DEPTH)) u_rptr (
      .clk(rd_clk), .clr(rd_zero), .en(rd_go), .ptr(rptr), .armed(r_armed)
   );

   lb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .wclk(wr_clk), .we(w_store), .waddr(wptr), .wdata(wr_data),
      .rclk(rd_clk), .re(r_fetch), .raddr(rptr), .rdata(fetched)
   );

   lb_rd_out #(.WIDTH(WIDTH), .MUTE_OFF(MUTE_OFF)) u_out (
      .rclk(rd_clk), .armed(r_armed), .go(rd_go), .zero(rd_zero),
      .word(fetched), .bus(rd_data), .drive(rd_drive)
   );

   // R2: a write-reset edge is not a store edge; pointer sits at zero after it
   p_zero_no_step_r2: assert property (@(posedge wr_clk) disable iff (!w_armed)
      (wr_zero && wr_go) |=> wptr == '0);

   // R4: read pointer moves on each fetch
   p_fetch_moves_r4: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (r_fetch && rptr != AW'(DEPTH - 1)) |=> rptr == $past(rptr) + AW'(1));
endmodule

// File: tb/tb_line_delay_buf.sv
`timescale 1ns/100ps
module tb_line_delay_buf;
   localparam int unsigned DEPTH = 5048;

   logic       wr_clk = 1'b0, rd_clk = 1'b0;
   logic       wr_go = 1'b0, wr_zero = 1'b0, rd_go = 1'b0, rd_zero = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       rd_drive;
   real        rhalf = 5.0;

   int checks = 0, errors = 0, cyc = 0;

   line_delay_buf dut (
      .wr_clk(wr_clk), .wr_go(wr_go), .wr_zero(wr_zero), .wr_data(wr_data),
      .rd_clk(rd_clk), .rd_go(rd_go), .rd_zero(rd_zero),
      .rd_data(rd_data), .rd_drive(rd_drive)
   );

   always #5 wr_clk = ~wr_clk;
   always #(rhalf) rd_clk = ~rd_clk;

   localparam int unsigned     DLY_TAB  [4] = '{21, 37, 100, 5048};
   localparam logic [7:0]      SEED_TAB [4] = '{8'h11, 8'h5A, 8'hC3, 8'h07};

   function automatic logic [7:0] pat(int unsigned k, logic [7:0] seed);
      return 8'(k * 5 + (k >> 8) + seed);
   endfunction

   task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s rd_data actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk1(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s rd_drive actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge wr_clk);
      #1;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge wr_clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual %0d cycles expected fewer", cyc);
         summary();
         $finish;
      end
   end

   // common-clock delay run of n words (R7)
   task automatic run_delay(int unsigned n, logic [7:0] seed);
      wr_zero = 1'b1; wr_go = 1'b1; wr_data = 8'hEE; rd_go = 1'b0; rd_zero = 1'b0;
      for (int unsigned e = 0; e <= n + 8; e++) begin
         step();
         if (e == n) chk1("R3", rd_drive, 1'b0);
         if (e > n) begin
            chk1("R7", rd_drive, 1'b1);
            chk8("R7", rd_data, pat(e - n - 1, seed));
         end
         wr_zero = 1'b0;
         wr_go   = 1'b1;
         wr_data = pat(e, seed);
         rd_zero = (e + 1 == n);
         rd_go   = (e + 1 >= n);
      end
      wr_go = 1'b0; rd_go = 1'b0; rd_zero = 1'b0;
      step();
   endtask

   initial begin
      logic [7:0] exp_q [$];
      logic       go_pat [8];

      // reset state (R1, R3, R5)
      wr_zero = 1'b1; rd_zero = 1'b1;
      step();
      chk1("R3", rd_drive, 1'b0);
      wr_zero = 1'b0; rd_zero = 1'b0;
      step();
      chk1("R5", rd_drive, 1'b0);

      // table of delay runs (R7, R9 full-length delay)
      for (int i = 0; i < 4; i++) run_delay(DLY_TAB[i], SEED_TAB[i]);

      // enable gating and reset-cycle no-store (R1, R2)
      go_pat = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
      wr_zero = 1'b1; wr_go = 1'b1; wr_data = 8'hEE;
      step();
      wr_zero = 1'b0;
      for (int i = 0; i < 8; i++) begin
         wr_go = go_pat[i];
         wr_data = 8'(8'h10 + i);
         if (go_pat[i]) exp_q.push_back(8'(8'h10 + i));
         step();
      end
      wr_go = 1'b0;
      rd_zero = 1'b1; rd_go = 1'b1;
      step();
      chk1("R3", rd_drive, 1'b0);
      rd_zero = 1'b0;
      // reads with a gap (R4, R5)
      for (int i = 0; i < 7; i++) begin
         rd_go = (i != 2);
         step();
         if (i == 2) chk1("R5", rd_drive, 1'b0);
         else begin
            chk1("R4", rd_drive, 1'b1);
            chk8("R2", rd_data, exp_q.pop_front());
         end
      end
      rd_go = 1'b0;

      // write reset with enable low still rewinds (R1), read reset with enable low (R3)
      wr_zero = 1'b1; wr_go = 1'b0;
      step();
      wr_zero = 1'b0; wr_go = 1'b1; wr_data = 8'h55;
      step();
      wr_go = 1'b0; rd_zero = 1'b1; rd_go = 1'b0;
      step();
      chk1("R3", rd_drive, 1'b0);
      rd_zero = 1'b0; rd_go = 1'b1;
      step();
      chk8("R1", rd_data, 8'h55);
      rd_go = 1'b0;
      step();

      // wrap of both pointers (R6)
      wr_zero = 1'b1;
      step();
      wr_zero = 1'b0; wr_go = 1'b1;
      for (int unsigned k = 0; k < DEPTH + 3; k++) begin
         wr_data = pat(k, 8'h09);
         step();
      end
      wr_go = 1'b0; rd_zero = 1'b1;
      step();
      rd_zero = 1'b0; rd_go = 1'b1;
      for (int unsigned j = 0; j < DEPTH + 2; j++) begin
         int unsigned a;
         step();
         a = j % DEPTH;
         chk8("R6", rd_data, (a < 3) ? pat(DEPTH + a, 8'h09) : pat(a, 8'h09));
      end
      rd_go = 1'b0;
      step();

      // double-rate read of one line, twice (R8)
      wr_zero = 1'b1;
      step();
      wr_zero = 1'b0; wr_go = 1'b1;
      for (int unsigned k = 0; k < DEPTH; k++) begin
         wr_data = pat(k, 8'hA7);
         step();
      end
      wr_go = 1'b0;
      rhalf = 2.5;
      @(posedge rd_clk); #0.5;
      @(posedge rd_clk); #0.5;
      rd_zero = 1'b1; rd_go = 1'b1;
      @(posedge rd_clk); #0.5;
      chk1("R8", rd_drive, 1'b0);
      rd_zero = 1'b0;
      for (int unsigned j = 0; j < 2 * DEPTH; j++) begin
         @(posedge rd_clk); #0.5;
         chk8("R8", rd_data, pat(j % DEPTH, 8'hA7));
      end
      rd_go = 1'b0;
      @(posedge rd_clk); #0.5;
      chk1("R5", rd_drive, 1'b0);

      summary();
      $finish;
   end
endmodule